// File: doc/BRIEF.md
# Dual-CPU Edge Interrupt and Event Controller

This block turns asynchronous event lines into interrupt requests, event pulses and wake-up requests for two CPU subsystems. It has two kinds of input. A configurable input is synchronised and checked for edges. Rising and falling detection are each selected per input. A software trigger can raise the input too. A detected edge latches a pending flag, and each CPU sees that flag through its own interrupt mask. A direct input has no flag. Its synchronised rising edge produces a wake-up pulse for each CPU that has that input unmasked.

Software programs the block over a 32-bit word-addressed register bus with per-byte write enables. The configurable inputs are grouped in banks of 32. Each bank has its own rising-select, falling-select, software-trigger and pending registers. Each CPU then has its own section holding interrupt masks and event masks per bank, plus one wake mask for the direct inputs.

Top module: `evt_ctrl_top`

## Requirements
- R1: After reset every select, mask and pending register reads 0, and all interrupt, event and wake outputs are low.
- R2: A rising edge on configurable input i is sampled at clock edge k. If rising detection is selected and at least one CPU interrupt mask bit is set, pending bit i is set at edge k+2.
- R3: Falling detection works in the same way on a falling edge. With both selects set, either edge sets the flag. An edge whose direction is not selected sets nothing.
- R4: A selected edge sets no pending flag while both CPUs have interrupt mask bit i clear.
- R5: Writing 1 to a pending bit clears it. Writing 0 has no effect, and a byte whose enable bit is 0 is left unchanged.
- R6: A hardware edge and a clear of the same pending bit in the same cycle leave the bit set.
- R7: Writing 1 to software-trigger bit i sets pending bit i at the clock edge of the write, whatever the rising-select bit holds, subject to R4. The software-trigger register always reads 0.
- R8: When a CPU's event mask bit i is set, a selected edge or software trigger gives that CPU's event output bit i a single high cycle, starting at edge k+2 (or at the write edge). No flag is kept, and no interrupt mask is needed for the pulse.
- R9: One shared pending flag per input drives both CPUs. A CPU's interrupt output bit i is the pending flag ANDed with that CPU's interrupt mask bit i, so changing one CPU's mask does not affect the other CPU.
- R10: A rising edge on direct input j, sampled at edge k, makes the wake output of each CPU with wake-mask bit j set high for one cycle, starting at edge k+2. A falling edge, or a masked input, gives no wake, and no pending flag is touched.
- R11: A CPU's wake output is also high whenever any of its interrupt output bits is high.
- R12: Word address map, where bit n of a bank register stands for input 32·b+n. Bank b: 4b rising select, 4b+1 falling select, 4b+2 software trigger, 4b+3 pending. CPU c (0 or 1): 32+16c+2b interrupt mask, 32+16c+2b+1 event mask, 32+16c+15 direct wake mask. Byte enable bit m covers data bits 8m to 8m+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied asynchronously |
| cfg_in | input | N_CFG | Asynchronous configurable event lines |
| dir_in | input | N_DIR | Asynchronous direct event lines |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_cpu0 | output | N_CFG | Per-input interrupt lines for CPU 0 |
| irq_cpu1 | output | N_CFG | Per-input interrupt lines for CPU 1 |
| evt_cpu0 | output | N_CFG | One-cycle event pulses for CPU 0 |
| evt_cpu1 | output | N_CFG | One-cycle event pulses for CPU 1 |
| wake_cpu0 | output | 1 | Wake-up request for CPU 0 |
| wake_cpu1 | output | 1 | Wake-up request for CPU 1 |

## Verification
The hardest case to reach from the ports is R6, where a clear write and a newly detected edge meet in the same cycle. The bench counts the synchroniser latency exactly. It drives the input, lets two clock edges pass, and then issues the clear write so that the write lands on the same edge where the detected edge would set the flag. Event pulses are sampled in their single high cycle and again one cycle later, which shows that they are one cycle long and that no state is kept behind them.

// File: rtl/evt_ctrl_pkg.sv
package evt_ctrl_pkg;
   localparam int CPU_CNT     = 2;
   localparam int BANK_BITS   = 32;
   // per-bank configuration words
   localparam int CFG_STRIDE  = 4;
   localparam int OFF_RISE    = 0;
   localparam int OFF_FALL    = 1;
   localparam int OFF_SWT     = 2;
   localparam int OFF_PEND    = 3;
   // per-CPU mask words
   localparam int CPU_BASE    = 32;
   localparam int CPU_STRIDE  = 16;
   localparam int OFF_DMASK   = 15;
   localparam int MAX_BANKS   = 7;

   function automatic logic [31:0] be_to_bits(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_in,
   input  logic [N-1:0] rise_sel,
   input  logic [N-1:0] fall_sel,
   output logic [N-1:0] hit
);
   logic [STAGES-1:0][N-1:0] chain;
   logic [N-1:0]             prev;
   logic [N-1:0]             sync_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evt_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= async_in;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_q = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= sync_q;
   end

   assign hit = (sync_q & ~prev & rise_sel) | (~sync_q & prev & fall_sel);
endmodule

// File: rtl/evt_regs.sv
module evt_regs
   import evt_ctrl_pkg::*;
#(
   parameter int N_CFG  = 64,
   parameter int N_DIR  = 8,
   parameter int ADDR_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [31:0]                       wdata,
   input  logic [3:0]                        be,
   input  logic [N_CFG-1:0]                  pend,
   output logic [31:0]                       rdata,
   output logic [N_CFG-1:0]                  rise_en,
   output logic [N_CFG-1:0]                  fall_en,
   output logic [N_CFG-1:0]                  sw_pulse,
   output logic [N_CFG-1:0]                  pend_clr,
   output logic [CPU_CNT-1:0][N_CFG-1:0]     imask,
   output logic [CPU_CNT-1:0][N_CFG-1:0]     emask,
   output logic [CPU_CNT-1:0][N_DIR-1:0]     dmask
);
   localparam int NB = N_CFG / BANK_BITS;

   logic [31:0] bmask;
   assign bmask = be_to_bits(be);

   function automatic logic match(input logic [ADDR_W-1:0] a, input int target);
      return a == ADDR_W'(target);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en <= '0;
         fall_en <= '0;
         imask   <= '0;
         emask   <= '0;
         dmask   <= '0;
      end else if (wr) begin
         for (int b = 0; b < NB; b++) begin
            if (match(addr, b*CFG_STRIDE + OFF_RISE))
               rise_en[b*32 +: 32] <= (rise_en[b*32 +: 32] & ~bmask) | (wdata & bmask);
            if (match(addr, b*CFG_STRIDE + OFF_FALL))
               fall_en[b*32 +: 32] <= (fall_en[b*32 +: 32] & ~bmask) | (wdata & bmask);
            for (int c = 0; c < CPU_CNT; c++) begin
               if (match(addr, CPU_BASE + c*CPU_STRIDE + 2*b))
                  imask[c][b*32 +: 32] <= (imask[c][b*32 +: 32] & ~bmask) | (wdata & bmask);
               if (match(addr, CPU_BASE + c*CPU_STRIDE + 2*b + 1))
                  emask[c][b*32 +: 32] <= (emask[c][b*32 +: 32] & ~bmask) | (wdata & bmask);
            end
         end
         for (int c = 0; c < CPU_CNT; c++) begin
            if (match(addr, CPU_BASE + c*CPU_STRIDE + OFF_DMASK))
               dmask[c] <= (dmask[c] & ~bmask[N_DIR-1:0]) | (wdata[N_DIR-1:0] & bmask[N_DIR-1:0]);
         end
      end
   end

   // strobes derived from the current write
   always_comb begin
      sw_pulse = '0;
      pend_clr = '0;
      if (wr) begin
         for (int b = 0; b < NB; b++) begin
            if (match(addr, b*CFG_STRIDE + OFF_SWT))  sw_pulse[b*32 +: 32] = wdata & bmask;
            if (match(addr, b*CFG_STRIDE + OFF_PEND)) pend_clr[b*32 +: 32] = wdata & bmask;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NB; b++) begin
         if (match(addr, b*CFG_STRIDE + OFF_RISE)) rdata = rise_en[b*32 +: 32];
         if (match(addr, b*CFG_STRIDE + OFF_FALL)) rdata = fall_en[b*32 +: 32];
         if (match(addr, b*CFG_STRIDE + OFF_PEND)) rdata = pend[b*32 +: 32];
         for (int c = 0; c < CPU_CNT; c++) begin
            if (match(addr, CPU_BASE + c*CPU_STRIDE + 2*b))     rdata = imask[c][b*32 +: 32];
            if (match(addr, CPU_BASE + c*CPU_STRIDE + 2*b + 1)) rdata = emask[c][b*32 +: 32];
         end
      end
      for (int c = 0; c < CPU_CNT; c++) begin
         if (match(addr, CPU_BASE + c*CPU_STRIDE + OFF_DMASK)) rdata = 32'(dmask[c]);
      end
   end
endmodule

// File: rtl/evt_pending.sv
module evt_pending #(
   parameter int N = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_vec) | set_vec;
   end

   // R2 R6
   property p_set_sticks;
      @(posedge clk) disable iff (!rst_n)
         (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec));
   endproperty
   set_wins_chk: assert property (p_set_sticks);

   // R5
   property p_clear_works;
      @(posedge clk) disable iff (!rst_n)
         (|clr_vec) |=> ((pend & $past(clr_vec & ~set_vec)) == '0);
   endproperty
   clear_bit_chk: assert property (p_clear_works);

   // R5
   property p_hold_untouched;
      @(posedge clk) disable iff (!rst_n)
         1'b1 |=> (((pend ^ $past(pend)) & ~$past(set_vec | clr_vec)) == '0);
   endproperty
   pend_hold_chk: assert property (p_hold_untouched);
endmodule

// File: rtl/evt_cpu_gate.sv
module evt_cpu_gate #(
   parameter int N     = 64,
   parameter int N_DIR = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pend,
   input  logic [N-1:0]     imask,
   input  logic [N-1:0]     emask,
   input  logic [N-1:0]     edge_hit,
   input  logic [N_DIR-1:0] dir_hit,
   input  logic [N_DIR-1:0] dmask,
   output logic [N-1:0]     irq,
   output logic [N-1:0]     evt,
   output logic             wake
);
   logic dir_wake_q;

   assign irq = pend & imask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt        <= '0;
         dir_wake_q <= 1'b0;
      end else begin
         evt        <= edge_hit & emask;
         dir_wake_q <= |(dir_hit & dmask);
      end
   end

   assign wake = (|irq) | dir_wake_q;

   // R8
   property p_evt_needs_mask;
      @(posedge clk) disable iff (!rst_n)
         1'b1 |-> ((evt & ~$past(emask)) == '0);
   endproperty
   evt_masked_chk: assert property (p_evt_needs_mask);

   // R10 R11
   property p_wake_source;
      @(posedge clk) disable iff (!rst_n)
         wake |-> ((|irq) || $past(|(dir_hit & dmask)));
   endproperty
   wake_source_chk: assert property (p_wake_source);
endmodule

// File: rtl/evt_ctrl_top.sv
module evt_ctrl_top
   import evt_ctrl_pkg::*;
#(
   parameter int N_CFG       = 64,
   parameter int N_DIR       = 8,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CFG-1:0]  cfg_in,
   input  logic [N_DIR-1:0]  dir_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [3:0]        bus_be,
   output logic [31:0]       bus_rdata,
   output logic [N_CFG-1:0]  irq_cpu0,
   output logic [N_CFG-1:0]  irq_cpu1,
   output logic [N_CFG-1:0]  evt_cpu0,
   output logic [N_CFG-1:0]  evt_cpu1,
   output logic              wake_cpu0,
   output logic              wake_cpu1
);
   localparam int NB = N_CFG / BANK_BITS;

   generate
      if (N_CFG % BANK_BITS != 0 || NB < 1 || NB > MAX_BANKS) begin : g_bad_ncfg
         $error("evt_ctrl_top: N_CFG must be a multiple of 32 between 32 and 224");
      end
      if (N_DIR < 1 || N_DIR > 32) begin : g_bad_ndir
         $error("evt_ctrl_top: N_DIR must be 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("evt_ctrl_top: ADDR_W must be at least 6");
      end
   endgenerate

   logic [N_CFG-1:0]              rise_en, fall_en, sw_pulse, pend_clr, pend;
   logic [N_CFG-1:0]              hw_hit, edge_hit, pend_set;
   logic [N_DIR-1:0]              dir_hit;
   logic [CPU_CNT-1:0][N_CFG-1:0] imask, emask, irq_all, evt_all;
   logic [CPU_CNT-1:0][N_DIR-1:0] dmask;
   logic [CPU_CNT-1:0]            wake_all;
   logic [N_DIR-1:0]              dir_rise_sel, dir_fall_sel;

   assign dir_rise_sel = '1;
   assign dir_fall_sel = '0;

   evt_regs #(.N_CFG(N_CFG), .N_DIR(N_DIR), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .be(bus_be), .pend(pend), .rdata(bus_rdata), .rise_en(rise_en),
      .fall_en(fall_en), .sw_pulse(sw_pulse), .pend_clr(pend_clr),
      .imask(imask), .emask(emask), .dmask(dmask)
   );

   evt_sync_edge #(.N(N_CFG), .STAGES(SYNC_STAGES)) u_cfg_edge (
      .clk(clk), .rst_n(rst_n), .async_in(cfg_in),
      .rise_sel(rise_en), .fall_sel(fall_en), .hit(hw_hit)
   );

   evt_sync_edge #(.N(N_DIR), .STAGES(SYNC_STAGES)) u_dir_edge (
      .clk(clk), .rst_n(rst_n), .async_in(dir_in),
      .rise_sel(dir_rise_sel), .fall_sel(dir_fall_sel), .hit(dir_hit)
   );

   assign edge_hit = hw_hit | sw_pulse;
   assign pend_set = edge_hit & (imask[0] | imask[1]);

   evt_pending #(.N(N_CFG)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_vec(pend_set), .clr_vec(pend_clr), .pend(pend)
   );

   generate
      for (genvar c = 0; c < CPU_CNT; c++) begin : g_cpu
         evt_cpu_gate #(.N(N_CFG), .N_DIR(N_DIR)) u_gate (
            .clk(clk), .rst_n(rst_n), .pend(pend), .imask(imask[c]),
            .emask(emask[c]), .edge_hit(edge_hit), .dir_hit(dir_hit),
            .dmask(dmask[c]), .irq(irq_all[c]), .evt(evt_all[c]),
            .wake(wake_all[c])
         );
      end
   endgenerate

   assign irq_cpu0  = irq_all[0];
   assign irq_cpu1  = irq_all[1];
   assign evt_cpu0  = evt_all[0];
   assign evt_cpu1  = evt_all[1];
   assign wake_cpu0 = wake_all[0];
   assign wake_cpu1 = wake_all[1];

   // R4
   property p_pend_needs_imask;
      @(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((pend & ~$past(pend) & ~$past(imask[0] | imask[1])) == '0);
   endproperty
   pend_masked_chk: assert property (p_pend_needs_imask);
endmodule

// File: tb/tb_evt_ctrl_top.sv
module tb_evt_ctrl_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cfg_in = '0;
   logic [7:0]  dir_in = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic [63:0] irq_cpu0, irq_cpu1, evt_cpu0, evt_cpu1;
   logic        wake_cpu0, wake_cpu1;
   int          checks = 0;
   int          failures = 0;

   always #2 clk = ~clk;

   evt_ctrl_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .dir_in(dir_in),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_rdata(bus_rdata), .irq_cpu0(irq_cpu0),
      .irq_cpu1(irq_cpu1), .evt_cpu0(evt_cpu0), .evt_cpu1(evt_cpu1),
      .wake_cpu0(wake_cpu0), .wake_cpu1(wake_cpu1)
   );

   // fields: rise fall im0 im1 em0 em1 dir(1=falling) exp_pend exp_e0 exp_e1
   localparam int NV = 10;
   localparam logic [9:0] VEC [NV] = '{
      10'b1010000100, 10'b1001100110, 10'b0110001100, 10'b1010001000,
      10'b0110000000, 10'b1111000100, 10'b1100010001, 10'b1010110111,
      10'b0000100000, 10'b1101101110
   };

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [9:0]  v;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      brd(8'd0, d);  chk("R1", "rise bank0", 64'(d), 0);
      brd(8'd3, d);  chk("R1", "pend bank0", 64'(d), 0);
      brd(8'd32, d); chk("R1", "imask cpu0", 64'(d), 0);
      brd(8'd47, d); chk("R1", "dmask cpu0", 64'(d), 0);
      chk("R1", "irq outputs", irq_cpu0 | irq_cpu1, 0);
      chk("R1", "evt/wake outputs", {evt_cpu0 | evt_cpu1, 62'b0, wake_cpu0, wake_cpu1} == 0, 1);

      // R2 R3 R4 R8 R9 table walk on input 3
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         bwr(8'd0, 0, 4'hF); bwr(8'd1, 0, 4'hF);
         bwr(8'd32, 0, 4'hF); bwr(8'd33, 0, 4'hF);
         bwr(8'd48, 0, 4'hF); bwr(8'd49, 0, 4'hF);
         cfg_in[3] = v[3];
         repeat (4) tick();
         bwr(8'd3, 32'hFFFF_FFFF, 4'hF);
         bwr(8'd0, {28'b0, v[9], 3'b0}, 4'hF);
         bwr(8'd1, {28'b0, v[8], 3'b0}, 4'hF);
         bwr(8'd32, {28'b0, v[7], 3'b0}, 4'hF);
         bwr(8'd48, {28'b0, v[6], 3'b0}, 4'hF);
         bwr(8'd33, {28'b0, v[5], 3'b0}, 4'hF);
         bwr(8'd49, {28'b0, v[4], 3'b0}, 4'hF);
         cfg_in[3] = ~v[3];
         tick(); tick();
         chk("R8", $sformatf("vec%0d evt before latency", i), 64'(evt_cpu0[3] | evt_cpu1[3]), 0);
         tick();
         chk("R8", $sformatf("vec%0d evt0", i), 64'(evt_cpu0[3]), 64'(v[1]));
         chk("R8", $sformatf("vec%0d evt1", i), 64'(evt_cpu1[3]), 64'(v[0]));
         chk("R9", $sformatf("vec%0d irq0", i), 64'(irq_cpu0[3]), 64'(v[2] & v[7]));
         chk("R9", $sformatf("vec%0d irq1", i), 64'(irq_cpu1[3]), 64'(v[2] & v[6]));
         brd(8'd3, d);
         chk("R2", $sformatf("vec%0d pend (R3 R4)", i), 64'(d[3]), 64'(v[2]));
         tick();
         chk("R8", $sformatf("vec%0d evt one cycle", i), 64'(evt_cpu0[3] | evt_cpu1[3]), 0);
      end
      bwr(8'd0, 0, 4'hF); bwr(8'd1, 0, 4'hF);
      bwr(8'd32, 0, 4'hF); bwr(8'd33, 0, 4'hF);
      bwr(8'd48, 0, 4'hF); bwr(8'd49, 0, 4'hF);
      bwr(8'd3, 32'hFFFF_FFFF, 4'hF);

      // R7 software trigger with rising select off
      bwr(8'd32, 32'h20, 4'hF);
      bwr(8'd33, 32'h20, 4'hF);
      bwr(8'd2, 32'h20, 4'hF);
      chk("R8", "sw evt0 pulse", 64'(evt_cpu0[5]), 1);
      brd(8'd3, d); chk("R7", "sw sets pend", 64'(d[5]), 1);
      brd(8'd2, d); chk("R7", "swtrig reads 0", 64'(d), 0);
      tick();
      chk("R8", "sw evt0 ends", 64'(evt_cpu0[5]), 0);

      // R5 clear semantics
      bwr(8'd3, 32'h0, 4'hF);
      brd(8'd3, d); chk("R5", "write 0 keeps", 64'(d[5]), 1);
      bwr(8'd3, 32'h20, 4'b1110);
      brd(8'd3, d); chk("R5", "disabled byte keeps", 64'(d[5]), 1);
      bwr(8'd3, 32'h20, 4'b0001);
      brd(8'd3, d); chk("R5", "write 1 clears", 64'(d[5]), 0);
      chk("R5", "irq0 gone", 64'(irq_cpu0[5]), 0);

      // R6 set wins over same-cycle clear
      bwr(8'd0, 32'h40, 4'hF);
      bwr(8'd32, 32'h40, 4'hF);
      cfg_in[6] = 1'b1;
      tick(); tick();
      bwr(8'd3, 32'h40, 4'hF);
      brd(8'd3, d); chk("R6", "set wins", 64'(d[6]), 1);
      bwr(8'd3, 32'h40, 4'hF);
      brd(8'd3, d); chk("R6", "later clear", 64'(d[6]), 0);

      // R9 shared flag, independent masks
      bwr(8'd0, 32'h80, 4'hF);
      bwr(8'd32, 32'h80, 4'hF);
      bwr(8'd48, 32'h80, 4'hF);
      cfg_in[7] = 1'b1;
      repeat (3) tick();
      chk("R9", "both irq", {62'b0, irq_cpu0[7], irq_cpu1[7]}, 3);
      bwr(8'd48, 0, 4'hF);
      chk("R9", "cpu1 masked off", {62'b0, irq_cpu0[7], irq_cpu1[7]}, 2);
      bwr(8'd3, 32'hFFFF_FFFF, 4'hF);
      bwr(8'd32, 0, 4'hF); bwr(8'd0, 0, 4'hF);

      // R12 second bank, input 40 = bank1 bit 8, byte-lane write
      bwr(8'd4, 32'h100, 4'b0010);
      bwr(8'd50, 32'h100, 4'hF);
      brd(8'd50, d); chk("R12", "imask cpu1 bank1 readback", 64'(d), 64'h100);
      cfg_in[40] = 1'b1;
      repeat (3) tick();
      chk("R12", "irq1 input40", 64'(irq_cpu1[40]), 1);
      chk("R9", "irq0 input40", 64'(irq_cpu0[40]), 0);
      chk("R11", "wake pair", {62'b0, wake_cpu0, wake_cpu1}, 1);
      brd(8'd7, d); chk("R12", "pend bank1", 64'(d), 64'h100);
      brd(8'd3, d); chk("R12", "pend bank0 clean", 64'(d), 0);
      bwr(8'd7, 32'h100, 4'hF);
      chk("R11", "wake1 drops", {62'b0, irq_cpu1[40], wake_cpu1}, 0);

      // R10 direct input 2, cpu0 only
      bwr(8'd47, 32'h4, 4'hF);
      dir_in[2] = 1'b1;
      tick(); tick();
      chk("R10", "no wake yet", 64'(wake_cpu0), 0);
      tick();
      chk("R10", "wake pulse", {62'b0, wake_cpu0, wake_cpu1}, 2);
      tick();
      chk("R10", "wake one cycle", 64'(wake_cpu0), 0);
      dir_in[2] = 1'b0;
      repeat (3) tick();
      chk("R10", "fall no wake", {62'b0, wake_cpu0, wake_cpu1}, 0);
      brd(8'd3, d); chk("R10", "no pend from direct", 64'(d), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule